// File: doc/BRIEF.md
# Banked UART Register Access Decoder

This block is the host-side register file and address decoder of a 16550-style UART. A synchronous bus with a 3-bit offset, byte-wide write and read data, and separate read and write strobes reaches every register through eight consecutive offsets. Which register an offset reaches is set by two things. The first is the divisor-access bit, which is the top bit of the line control register. The second is a bank flag that is raised by writing a reserved key value (0xBF) to the line control register.

Writing the key opens an extended bank, which holds an enhanced-feature register and four flow-control character registers. The stored line format does not change when the key is written. A separate additional-control register is reached through an indexed port, using the scratch register as the index. It decides whether the upper indexed entries can be written and read. The serial path, FIFOs and interrupt logic sit outside the block. Their status reaches the block through plain input ports, and the data, FIFO-control and modem-control registers are kept as simple storage.

Top module: `uart_regbank_dec`

## Requirements
- R1: After reset, line control, divisor, additional control, interrupt enable, FIFO control, modem control, scratch, transmit holding, extended-bank and indexed registers are all 0, the normal bank is selected and `rdata_o` is 0.
- R2: With divisor access off and the normal bank selected, a read at offset 0 returns `rx_data_i`, 1 returns interrupt enable, 2 returns `isr_i`, 3 returns line control, 4 returns modem control, 6 returns `msr_i` and 7 returns scratch. A write at offset 0 sets `thr_o`, 1 sets `ier_o`, 2 sets `fcr_o`, 4 sets `mcr_o` and 7 sets scratch.
- R3: While line-control bit 7 is 1, offsets 0 and 1 read and write the low and high divisor bytes (`divisor_o` = {high, low}), and transmit holding and interrupt enable are left unchanged. The divisor changes only through these two offsets.
- R4: A write of 0xBF to offset 3 sets `ext_bank_o`, sets line-control bit 7 and keeps bits 6:0. The line-control fields are: bits 1:0 `word_len_o`, bit 2 `stop_bits_o`, bits 5:3 `parity_cfg_o`, bit 6 `break_o`, bit 7 `dlab_o`. The extended bank is never selected while `dlab_o` is 0.
- R5: In the extended bank, offset 2 reaches `efr_o` and offsets 4 to 7 reach flow-character bytes 0 to 3 (byte k is `flow_chars_o[8k+7:8k]`). Offset 3 reads the stored line control and offsets 0 and 1 reach the divisor. Normal-bank registers are left unchanged.
- R6: A write of any other value to offset 3 clears `ext_bank_o` and stores that value as the line control.
- R7: The line status and modem status locations are read-only. A write at offset 6 changes no register, and a read of offset 6 keeps returning `msr_i`. A read of offset 5 returns `lsr_i` while `acr_o` bit 6 is 0, whatever has been written to offset 5.
- R8: In the normal bank, a write at offset 5 goes to indexed entry number SPR. Entry 0 is the additional-control register (`acr_o`) and can always be written. Entries 1 to ICR_DEPTH-1 take the write only while `acr_o` bit 7 is 1. Indices from ICR_DEPTH upward are ignored. Entry k is `icr_o[8k+7:8k]`.
- R9: While `acr_o` bit 6 is 1, a read of offset 5 in the normal bank returns indexed entry SPR. It returns 0 for an index of ICR_DEPTH or more, and for indices 1 and up while `acr_o` bit 7 is 0.
- R10: `rdata_o` is loaded on the clock edge that samples `rd_i` high and holds its value otherwise. A read and a write in the same cycle return the value from before the write.
- R11: Extended-bank and normal-bank registers keep their contents across leaving and re-entering the extended bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| rdata_o | output | 8 | Registered read data |
| rx_data_i | input | 8 | Receive holding byte from the stub |
| isr_i | input | 8 | Interrupt status from the stub |
| lsr_i | input | 8 | Line status from the stub |
| msr_i | input | 8 | Modem status from the stub |
| thr_o | output | 8 | Transmit holding register |
| ier_o | output | 8 | Interrupt enable register |
| fcr_o | output | 8 | FIFO control register |
| mcr_o | output | 8 | Modem control register |
| word_len_o | output | 2 | Line control bits 1:0 |
| stop_bits_o | output | 1 | Line control bit 2 |
| parity_cfg_o | output | 3 | Line control bits 5:3 |
| break_o | output | 1 | Line control bit 6 |
| dlab_o | output | 1 | Divisor access bit, line control bit 7 |
| ext_bank_o | output | 1 | Extended bank selected |
| divisor_o | output | 16 | Divisor {high, low} |
| acr_o | output | 8 | Additional control register |
| efr_o | output | 8 | Enhanced-feature register |
| flow_chars_o | output | 32 | Four flow-control character bytes |
| icr_o | output | 8*ICR_DEPTH | Indexed registers, entry 0 first |

## Verification
The bench builds the block with ICR_DEPTH = 4. This makes a sweep of the scratch index from 0 to 15 cover the additional-control entry, the gated entries 1 to 3 and out-of-range indices, under all four combinations of the two gating bits. Every one of the 256 line-control values is written on top of a varying previous value, so both the key-write path and the plain store are checked against an arithmetic model. Divisor, bank-switch, read-only and read-timing scenarios then run as directed sequences.

// File: rtl/urb_pkg.sv
// Package: shared types for the banked UART register decoder.
// Assumes an 8-offset window and byte-wide registers.
package urb_pkg;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned WIN_AW = 3;
    localparam int unsigned FLOW_N = 4;
    localparam int unsigned FLOW_IW = $clog2(FLOW_N);

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_RXTX,
        SEL_IER,
        SEL_DLL,
        SEL_DLM,
        SEL_ISRFCR,
        SEL_LCR,
        SEL_MCR,
        SEL_LSRIDX,
        SEL_MSR,
        SEL_SPR,
        SEL_EFR,
        SEL_FLOW
    } reg_sel_e;
endpackage

// File: rtl/urb_decode.sv
// Module: offset decoder. Maps a window offset to a register select
// from the divisor-access bit and the extended-bank flag.
// Assumes the extended bank is only open while divisor access is on.
module urb_decode
    import urb_pkg::*;
(
    input  logic [WIN_AW-1:0]  addr_i,
    input  logic               dlab_i,
    input  logic               ext_i,
    output reg_sel_e           sel_o,
    output logic [FLOW_IW-1:0] flow_idx_o
);
    // Purpose: combinational offset-to-register map.
    always_comb begin
        sel_o      = SEL_NONE;
        flow_idx_o = addr_i[FLOW_IW-1:0];
        case (addr_i)
            3'd0:    sel_o = dlab_i ? SEL_DLL : SEL_RXTX;
            3'd1:    sel_o = dlab_i ? SEL_DLM : SEL_IER;
            3'd2:    sel_o = ext_i ? SEL_EFR : SEL_ISRFCR;
            3'd3:    sel_o = SEL_LCR;
            3'd4:    sel_o = ext_i ? SEL_FLOW : SEL_MCR;
            3'd5:    sel_o = ext_i ? SEL_FLOW : SEL_LSRIDX;
            3'd6:    sel_o = ext_i ? SEL_FLOW : SEL_MSR;
            3'd7:    sel_o = ext_i ? SEL_FLOW : SEL_SPR;
            default: sel_o = SEL_NONE;
        endcase
    end
endmodule

// File: rtl/urb_core_regs.sv
// Module: normal-bank storage (line control, bank flag, divisor,
// interrupt enable, FIFO control, modem control, scratch, transmit).
// Assumes one write per cycle, qualified by the decoded select.
module urb_core_regs
    import urb_pkg::*;
#(
    parameter logic [BYTE_W-1:0] BANK_KEY = 8'hBF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_i,
    input  reg_sel_e          sel_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] lcr_o,
    output logic              ext_o,
    output logic [BYTE_W-1:0] dll_o,
    output logic [BYTE_W-1:0] dlm_o,
    output logic [BYTE_W-1:0] ier_o,
    output logic [BYTE_W-1:0] fcr_o,
    output logic [BYTE_W-1:0] mcr_o,
    output logic [BYTE_W-1:0] spr_o,
    output logic [BYTE_W-1:0] thr_o
);
    logic lcr_we;
    assign lcr_we = wr_i && (sel_i == SEL_LCR);

    // Purpose: line control and bank flag; the key keeps the format bits.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            lcr_o <= '0;
            ext_o <= 1'b0;
        end else if (lcr_we) begin
            if (wdata_i == BANK_KEY) begin
                lcr_o[BYTE_W-1] <= 1'b1;
                ext_o           <= 1'b1;
            end else begin
                lcr_o <= wdata_i;
                ext_o <= 1'b0;
            end
        end
    end

    // Purpose: divisor latch bytes.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dll_o <= '0;
            dlm_o <= '0;
        end else if (wr_i) begin
            if (sel_i == SEL_DLL) dll_o <= wdata_i;
            if (sel_i == SEL_DLM) dlm_o <= wdata_i;
        end
    end

    // Purpose: plain normal-bank storage registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ier_o <= '0;
            fcr_o <= '0;
            mcr_o <= '0;
            spr_o <= '0;
            thr_o <= '0;
        end else if (wr_i) begin
            case (sel_i)
                SEL_RXTX:   thr_o <= wdata_i;
                SEL_IER:    ier_o <= wdata_i;
                SEL_ISRFCR: fcr_o <= wdata_i;
                SEL_MCR:    mcr_o <= wdata_i;
                SEL_SPR:    spr_o <= wdata_i;
                default:    ;
            endcase
        end
    end
endmodule

// File: rtl/urb_ext_regs.sv
// Module: extended-bank storage: enhanced-feature register and the
// flow-control character bytes. Assumes selects come from urb_decode.
module urb_ext_regs
    import urb_pkg::*;
(
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     wr_i,
    input  reg_sel_e                 sel_i,
    input  logic [FLOW_IW-1:0]       flow_idx_i,
    input  logic [BYTE_W-1:0]        wdata_i,
    output logic [BYTE_W-1:0]        efr_o,
    output logic [FLOW_N-1:0][BYTE_W-1:0] flow_o
);
    logic [FLOW_N-1:0] flow_we;

    // Purpose: per-byte write enables for the flow characters.
    for (genvar k = 0; k < FLOW_N; k++) begin : g_flow_we
        assign flow_we[k] = wr_i && (sel_i == SEL_FLOW) && (flow_idx_i == FLOW_IW'(k));
    end

    // Purpose: enhanced-feature register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                          efr_o <= '0;
        else if (wr_i && sel_i == SEL_EFR)    efr_o <= wdata_i;
    end

    // Purpose: flow-control character storage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            flow_o <= '0;
        end else begin
            for (int k = 0; k < FLOW_N; k++) begin
                if (flow_we[k]) flow_o[k] <= wdata_i;
            end
        end
    end
endmodule

// File: rtl/urb_index_regs.sv
// Module: indexed register set. Entry 0 is the additional-control
// register; its bit 7 gates the other entries and bit 6 enables reads.
// Assumes the index comes from the scratch register and 2 <= DEPTH <= 256.
module urb_index_regs
    import urb_pkg::*;
#(
    parameter int unsigned DEPTH = 8
) (
    input  logic                         clk_i,
    input  logic                         rst_ni,
    input  logic                         wr_i,
    input  reg_sel_e                     sel_i,
    input  logic [BYTE_W-1:0]            idx_i,
    input  logic [BYTE_W-1:0]            wdata_i,
    output logic [DEPTH-1:0][BYTE_W-1:0] ent_o,
    output logic                         rd_en_o,
    output logic [BYTE_W-1:0]            rd_val_o
);
    localparam int unsigned EXT_EN_BIT = 7;
    localparam int unsigned RD_EN_BIT  = 6;

    logic [DEPTH-1:0] ent_we;
    logic             port_wr;
    assign port_wr = wr_i && (sel_i == SEL_LSRIDX);

    // Purpose: write enables; entry 0 always, others behind the gate bit.
    for (genvar k = 0; k < DEPTH; k++) begin : g_ent_we
        if (k == 0) begin : g_ctrl
            assign ent_we[k] = port_wr && (idx_i == '0);
        end else begin : g_gated
            assign ent_we[k] = port_wr && (idx_i == BYTE_W'(k)) && ent_o[0][EXT_EN_BIT];
        end
    end

    // Purpose: indexed entry storage.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ent_o <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (ent_we[k]) ent_o[k] <= wdata_i;
            end
        end
    end

    assign rd_en_o = ent_o[0][RD_EN_BIT];

    // Purpose: gated read value for the current index.
    always_comb begin
        rd_val_o = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (idx_i == BYTE_W'(k) && (k == 0 || ent_o[0][EXT_EN_BIT])) begin
                rd_val_o = ent_o[k];
            end
        end
    end
endmodule

// File: rtl/uart_regbank_dec.sv
// Module: top of the banked UART register decoder. Joins the offset
// decoder, the three storage groups and the registered read mux.
// Assumes status inputs come from stubs and are stable around a read.
module uart_regbank_dec
    import urb_pkg::*;
#(
    parameter int unsigned       ICR_DEPTH = 8,
    parameter logic [7:0]        BANK_KEY  = 8'hBF,
    localparam int unsigned      ICR_W     = ICR_DEPTH * 8,
    localparam int unsigned      FLOW_W    = 4 * 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        addr_i,
    input  logic [7:0]        wdata_i,
    input  logic              wr_i,
    input  logic              rd_i,
    output logic [7:0]        rdata_o,
    input  logic [7:0]        rx_data_i,
    input  logic [7:0]        isr_i,
    input  logic [7:0]        lsr_i,
    input  logic [7:0]        msr_i,
    output logic [7:0]        thr_o,
    output logic [7:0]        ier_o,
    output logic [7:0]        fcr_o,
    output logic [7:0]        mcr_o,
    output logic [1:0]        word_len_o,
    output logic              stop_bits_o,
    output logic [2:0]        parity_cfg_o,
    output logic              break_o,
    output logic              dlab_o,
    output logic              ext_bank_o,
    output logic [15:0]       divisor_o,
    output logic [7:0]        acr_o,
    output logic [7:0]        efr_o,
    output logic [FLOW_W-1:0] flow_chars_o,
    output logic [ICR_W-1:0]  icr_o
);
    reg_sel_e                        sel;
    logic [FLOW_IW-1:0]              flow_idx;
    logic [BYTE_W-1:0]               lcr, dll, dlm, spr, idx_val;
    logic                            idx_rd_en;
    logic [FLOW_N-1:0][BYTE_W-1:0]   flow;
    logic [ICR_DEPTH-1:0][BYTE_W-1:0] ent;
    logic [BYTE_W-1:0]               rd_mux;

    urb_decode u_decode (
        .addr_i     (addr_i),
        .dlab_i     (lcr[BYTE_W-1]),
        .ext_i      (ext_bank_o),
        .sel_o      (sel),
        .flow_idx_o (flow_idx)
    );

    urb_core_regs #(.BANK_KEY(BANK_KEY)) u_core (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .wr_i    (wr_i),
        .sel_i   (sel),
        .wdata_i (wdata_i),
        .lcr_o   (lcr),
        .ext_o   (ext_bank_o),
        .dll_o   (dll),
        .dlm_o   (dlm),
        .ier_o   (ier_o),
        .fcr_o   (fcr_o),
        .mcr_o   (mcr_o),
        .spr_o   (spr),
        .thr_o   (thr_o)
    );

    urb_ext_regs u_ext (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (wr_i),
        .sel_i      (sel),
        .flow_idx_i (flow_idx),
        .wdata_i    (wdata_i),
        .efr_o      (efr_o),
        .flow_o     (flow)
    );

    urb_index_regs #(.DEPTH(ICR_DEPTH)) u_index (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_i     (wr_i),
        .sel_i    (sel),
        .idx_i    (spr),
        .wdata_i  (wdata_i),
        .ent_o    (ent),
        .rd_en_o  (idx_rd_en),
        .rd_val_o (idx_val)
    );

    assign word_len_o   = lcr[1:0];
    assign stop_bits_o  = lcr[2];
    assign parity_cfg_o = lcr[5:3];
    assign break_o      = lcr[6];
    assign dlab_o       = lcr[7];
    assign divisor_o    = {dlm, dll};
    assign flow_chars_o = flow;
    assign icr_o        = ent;
    assign acr_o        = ent[0];

    // Purpose: select the read value for the decoded register.
    always_comb begin
        case (sel)
            SEL_RXTX:   rd_mux = rx_data_i;
            SEL_IER:    rd_mux = ier_o;
            SEL_DLL:    rd_mux = dll;
            SEL_DLM:    rd_mux = dlm;
            SEL_ISRFCR: rd_mux = isr_i;
            SEL_LCR:    rd_mux = lcr;
            SEL_MCR:    rd_mux = mcr_o;
            SEL_LSRIDX: rd_mux = idx_rd_en ? idx_val : lsr_i;
            SEL_MSR:    rd_mux = msr_i;
            SEL_SPR:    rd_mux = spr;
            SEL_EFR:    rd_mux = efr_o;
            SEL_FLOW:   rd_mux = flow[flow_idx];
            default:    rd_mux = '0;
        endcase
    end

    // Purpose: register read data on a read strobe, hold otherwise.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)   rdata_o <= '0;
        else if (rd_i) rdata_o <= rd_mux;
    end
endmodule

// File: rtl/uart_regbank_dec_chk.sv
// Module: property checker for uart_regbank_dec, attached by bind.
// Assumes ICR_DEPTH >= 2.
module uart_regbank_dec_chk #(
    parameter int unsigned ICR_DEPTH = 8,
    parameter logic [7:0]  BANK_KEY  = 8'hBF,
    localparam int unsigned ICR_W    = ICR_DEPTH * 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [2:0]       addr_i,
    input logic [7:0]       wdata_i,
    input logic             wr_i,
    input logic             rd_i,
    input logic [7:0]       rdata_o,
    input logic [1:0]       word_len_o,
    input logic             stop_bits_o,
    input logic [2:0]       parity_cfg_o,
    input logic             break_o,
    input logic             dlab_o,
    input logic             ext_bank_o,
    input logic [15:0]      divisor_o,
    input logic [7:0]       mcr_o,
    input logic [7:0]       ier_o,
    input logic [7:0]       acr_o,
    input logic [ICR_W-1:0] icr_o
);
    logic [7:0] fmt;
    assign fmt = {dlab_o, break_o, parity_cfg_o, stop_bits_o, word_len_o};

    AST_KEY_KEEPS_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == 3'd3 && wdata_i == BANK_KEY) |=> (ext_bank_o && dlab_o && $stable(fmt[6:0]))); // R4
    AST_BANK_NEEDS_DLAB: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ext_bank_o |-> dlab_o); // R4
    AST_LEAVE_BANK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == 3'd3 && wdata_i != BANK_KEY) |=> (!ext_bank_o && fmt == $past(wdata_i))); // R6
    AST_DIVISOR_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(wr_i && dlab_o && addr_i[2:1] == 2'b00) |=> $stable(divisor_o)); // R3
    AST_MSR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == 3'd6 && !ext_bank_o) |=>
            ($stable(mcr_o) && $stable(ier_o) && $stable(acr_o) && $stable(divisor_o) && $stable(fmt))); // R7
    AST_ICR_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !acr_o[7] |=> $stable(icr_o[ICR_W-1:8])); // R8
    AST_RDATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !rd_i |=> $stable(rdata_o)); // R10
endmodule

bind uart_regbank_dec uart_regbank_dec_chk #(
    .ICR_DEPTH (ICR_DEPTH),
    .BANK_KEY  (BANK_KEY)
) chk_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .addr_i       (addr_i),
    .wdata_i      (wdata_i),
    .wr_i         (wr_i),
    .rd_i         (rd_i),
    .rdata_o      (rdata_o),
    .word_len_o   (word_len_o),
    .stop_bits_o  (stop_bits_o),
    .parity_cfg_o (parity_cfg_o),
    .break_o      (break_o),
    .dlab_o       (dlab_o),
    .ext_bank_o   (ext_bank_o),
    .divisor_o    (divisor_o),
    .mcr_o        (mcr_o),
    .ier_o        (ier_o),
    .acr_o        (acr_o),
    .icr_o        (icr_o)
);

// File: tb/uart_regbank_dec_tb_top.sv
// Bench: directed and swept checks of uart_regbank_dec with ICR_DEPTH = 4.
module uart_regbank_dec_tb_top;
    localparam int unsigned DEPTH = 4;
    localparam time         CLK_T = 20ns;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       addr = '0;
    logic [7:0]       wdata = '0;
    logic             wr = 1'b0, rd = 1'b0;
    logic [7:0]       rdata;
    logic [7:0]       rx_data = 8'h5A, isr = 8'hC1, lsr = 8'h60, msr = 8'hB0;
    logic [7:0]       thr, ier, fcr, mcr, acr, efr;
    logic [1:0]       word_len;
    logic             stop_bits, brk, dlab, ext_bank;
    logic [2:0]       parity_cfg;
    logic [15:0]      divisor;
    logic [31:0]      flow_chars;
    logic [DEPTH*8-1:0] icr;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_T/2) clk = ~clk;

    uart_regbank_dec #(.ICR_DEPTH(DEPTH)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata),
        .wr_i(wr), .rd_i(rd), .rdata_o(rdata),
        .rx_data_i(rx_data), .isr_i(isr), .lsr_i(lsr), .msr_i(msr),
        .thr_o(thr), .ier_o(ier), .fcr_o(fcr), .mcr_o(mcr),
        .word_len_o(word_len), .stop_bits_o(stop_bits), .parity_cfg_o(parity_cfg),
        .break_o(brk), .dlab_o(dlab), .ext_bank_o(ext_bank), .divisor_o(divisor),
        .acr_o(acr), .efr_o(efr), .flow_chars_o(flow_chars), .icr_o(icr)
    );

    function automatic logic [7:0] fmt_now();
        return {dlab, brk, parity_cfg, stop_bits, word_len};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        v = rdata;
    endtask

    task automatic rd_chk(input string req, input logic [2:0] a, input logic [7:0] exp);
        logic [7:0] v;
        bus_rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_T * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [7:0] mdl [16];
        logic [7:0] v;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 format", fmt_now(), 8'h00);
        chk("R1 bank", ext_bank, 1'b0);
        chk("R1 divisor", divisor, 16'h0);
        chk("R1 misc", {thr, ier, fcr, mcr, acr, efr}, 48'h0);
        chk("R1 ext/icr", {flow_chars, icr}, 64'h0);
        rd_chk("R1 lcr read", 3'd3, 8'h00);
        rd_chk("R1 ier read", 3'd1, 8'h00);

        // R2 normal-bank map
        bus_wr(3'd0, 8'hA5);
        bus_wr(3'd1, 8'h0F);
        bus_wr(3'd2, 8'h87);
        bus_wr(3'd4, 8'h13);
        bus_wr(3'd7, 8'h77);
        chk("R2 thr", thr, 8'hA5);
        chk("R2 ier", ier, 8'h0F);
        chk("R2 fcr", fcr, 8'h87);
        chk("R2 mcr", mcr, 8'h13);
        rd_chk("R2 off0", 3'd0, rx_data);
        rd_chk("R2 off1", 3'd1, 8'h0F);
        rd_chk("R2 off2", 3'd2, isr);
        rd_chk("R2 off3", 3'd3, 8'h00);
        rd_chk("R2 off4", 3'd4, 8'h13);
        rd_chk("R2 off6", 3'd6, msr);
        rd_chk("R2 off7", 3'd7, 8'h77);

        // R3 divisor access sweep
        bus_wr(3'd3, 8'h83);
        chk("R3 dlab", dlab, 1'b1);
        for (int k = 0; k < 16; k++) begin
            logic [7:0] lo, hi;
            lo = 8'((k * 29) & 255);
            hi = 8'((255 - k * 13) & 255);
            bus_wr(3'd0, lo);
            bus_wr(3'd1, hi);
            chk("R3 divisor", divisor, {hi, lo});
            rd_chk("R3 dll read", 3'd0, lo);
            rd_chk("R3 dlm read", 3'd1, hi);
        end
        chk("R3 thr untouched", thr, 8'hA5);
        chk("R3 ier untouched", ier, 8'h0F);
        bus_wr(3'd3, 8'h03);
        rd_chk("R3 rhr back", 3'd0, rx_data);
        chk("R3 divisor kept", divisor, {8'((255 - 15 * 13) & 255), 8'((15 * 29) & 255)});

        // R4 / R6 sweep of every line-control value
        for (int val = 0; val < 256; val++) begin
            logic [7:0] p, e;
            p = 8'((val * 37 + 11) & 255);
            if (p == 8'hBF) p = 8'h3B;
            bus_wr(3'd3, p);
            chk("R6 store", fmt_now(), p);
            chk("R6 bank off", ext_bank, 1'b0);
            bus_wr(3'd3, 8'(val));
            e = (val == 8'hBF) ? {1'b1, p[6:0]} : 8'(val);
            chk((val == 8'hBF) ? "R4 key format" : "R6 format", fmt_now(), e);
            chk((val == 8'hBF) ? "R4 key bank" : "R6 bank", ext_bank, (val == 8'hBF));
            rd_chk("R6 lcr read", 3'd3, e);
        end

        // R5 extended bank
        bus_wr(3'd3, 8'h03);
        bus_wr(3'd3, 8'hBF);
        chk("R4 key from 03", fmt_now(), 8'h83);
        bus_wr(3'd0, 8'h44);
        bus_wr(3'd1, 8'h55);
        bus_wr(3'd2, 8'hE0);
        for (int k = 0; k < 4; k++) bus_wr(3'(4 + k), 8'(8'h11 * (k + 1)));
        chk("R5 efr", efr, 8'hE0);
        chk("R5 flow", flow_chars, 32'h44332211);
        chk("R5 divisor", divisor, 16'h5544);
        rd_chk("R5 off2", 3'd2, 8'hE0);
        rd_chk("R5 off3", 3'd3, 8'h83);
        rd_chk("R5 off0", 3'd0, 8'h44);
        rd_chk("R5 off1", 3'd1, 8'h55);
        for (int k = 0; k < 4; k++) rd_chk("R5 flow read", 3'(4 + k), 8'(8'h11 * (k + 1)));
        chk("R5 normal untouched", {mcr, fcr, ier, thr}, 32'h13870FA5);
        bus_wr(3'd3, 8'h1B);
        chk("R6 exit format", fmt_now(), 8'h1B);
        chk("R6 exit bank", ext_bank, 1'b0);
        rd_chk("R11 mcr kept", 3'd4, 8'h13);
        rd_chk("R11 spr kept", 3'd7, 8'h77);
        rd_chk("R11 isr back", 3'd2, isr);
        chk("R11 ext kept", {efr, flow_chars}, 40'hE044332211);
        bus_wr(3'd3, 8'hBF);
        chk("R4 key from 1B", fmt_now(), 8'h9B);
        rd_chk("R11 flow reentry", 3'd4, 8'h11);
        rd_chk("R11 efr reentry", 3'd2, 8'hE0);
        bus_wr(3'd3, 8'h03);

        // R7 read-only status locations
        bus_wr(3'd7, 8'h40);
        bus_wr(3'd5, 8'hEE);
        chk("R7 icr untouched", icr, '0);
        rd_chk("R7 lsr read", 3'd5, lsr);
        bus_wr(3'd6, 8'hFF);
        rd_chk("R7 msr read", 3'd6, msr);
        msr = 8'h3C;
        rd_chk("R7 msr follows", 3'd6, 8'h3C);
        chk("R7 regs untouched", {mcr, ier, acr, fmt_now()}, 32'h130F0003);

        // R8 / R9 indexed sweep over gate combinations
        for (int g = 0; g < 4; g++) begin
            logic [7:0] a;
            a = 8'(g << 6);
            bus_wr(3'd7, 8'h00);
            bus_wr(3'd5, 8'h80);
            for (int i = 1; i < DEPTH; i++) begin
                bus_wr(3'd7, 8'(i));
                bus_wr(3'd5, 8'h00);
            end
            bus_wr(3'd7, 8'h00);
            bus_wr(3'd5, a);
            chk("R8 acr write", acr, a);
            for (int i = 1; i < 16; i++) begin
                logic [7:0] d;
                d = 8'((8'h20 + i * 5) & 255);
                bus_wr(3'd7, 8'(i));
                bus_wr(3'd5, d);
                mdl[i] = (i < DEPTH && a[7]) ? d : 8'h00;
            end
            chk("R8 icr contents", icr, {mdl[3], mdl[2], mdl[1], a});
            for (int i = 0; i < 16; i++) begin
                logic [7:0] e;
                if (!a[6])            e = lsr;
                else if (i == 0)      e = a;
                else if (i < DEPTH)   e = mdl[i];
                else                  e = 8'h00;
                bus_wr(3'd7, 8'(i));
                rd_chk(a[6] ? "R9 indexed read" : "R7 lsr with gate off", 3'd5, e);
            end
        end
        bus_wr(3'd7, 8'h00);
        bus_wr(3'd5, 8'h00);

        // R10 read timing
        bus_wr(3'd7, 8'h5C);
        @(negedge clk);
        addr = 3'd7; wdata = 8'hC5; wr = 1'b1; rd = 1'b1;
        @(negedge clk);
        wr = 1'b0; rd = 1'b0;
        chk("R10 read before write", rdata, 8'h5C);
        rd_chk("R10 read after write", 3'd7, 8'hC5);
        rx_data = 8'h99;
        repeat (3) @(negedge clk);
        chk("R10 hold", rdata, 8'hC5);
        addr = 3'd0; rd = 1'b1;
        #1;
        chk("R10 not early", rdata, 8'hC5);
        @(negedge clk);
        rd = 1'b0;
        chk("R10 one-cycle latency", rdata, 8'h99);

        finish_run();
    end
endmodule